// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block drives the two-wire station management bus of an Ethernet PHY. It divides the system clock down to a management clock (MDC), serialises each frame onto a single data line (MDIO) and releases that line when the PHY has to answer. The data line is split into an output value, an output enable and an input sample, so the pad's tri-state buffer stays outside the block.

Software controls the block through two 32-bit words on a simple write-strobe/read-data port. A control word holds the run enable, the preamble suppression and the clock divider. A command word starts a transfer. Software writes the go flag together with the direction, the PHY address, the register address and, for a write, the data, all in one word. It then polls the same go flag until the hardware clears it. For a read, the PHY's answer is then found in the low half of that word.

Top module: `mdio_master`

## Requirements
- R1: The command word sits at byte address 0x08. It reads back as bit 31 busy, bit 30 direction (1 write, 0 read), bits 25:21 register address, bits 20:16 PHY address and bits 15:0 data, with every other bit zero.
- R2: The control word sits at byte address 0x04. Bit 30 is the enable, bit 20 suppresses the preamble and bits 7:0 hold the divider N. Bit 31 reads as the idle flag, and every other bit reads zero. After reset the control word reads 0x8000_0000 and the command word reads 0.
- R3: A write to the command word with bit 31 set, while the block is enabled and idle, starts a frame. Busy reads 1 from the next cycle until the frame completes.
- R4: MDC is low while idle and toggles every N+1 system clocks during a frame. Busy clears exactly 2·(N+1)·B clocks after the starting write edge, where B is 64 with preamble and 32 without. Each frame shows exactly B MDC rising edges.
- R5: A frame sends, MSB first: 32 ones (omitted when bit 20 is set), start 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, then the 5-bit register address.
- R6: A write frame continues with turnaround 10 and the 16 data bits, all driven with the output enable high.
- R7: A read frame drops the output enable for the two turnaround bits and the 16 data bits. It samples MDIO on the 16 data MDC rising edges, MSB first, and the result sits in bits 15:0 of the command word when busy clears.
- R8: The MDIO output changes only together with an MDC falling edge, so it is stable at every rising edge.
- R9: A command-word write while busy is ignored. The running frame and the stored direction and addresses are unchanged.
- R10: While the enable is clear, a command write does not start a frame: busy stays 0 and MDC stays low.
- R11: The idle flag reads 0 while a frame is being shifted and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte address for read and write |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Output enable of the MDIO driver |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
On every cycle, the assertions check the following. MDC rests low when no frame runs and holds between divider terminal counts. The MDIO output stays constant except at a falling MDC edge. The driver is released whenever a read bit is captured. A command write during a frame leaves the stored addresses and direction untouched. A disabled block never goes busy. Only the bench's scenarios can show the exact bit sequence on the wire for each divider, direction and preamble setting, the total frame length in clocks, the data returned from a modelled PHY and the register readback values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int WORD_W = 32;
    localparam logic [7:0] CTRL_OFS = 8'h04;
    localparam logic [7:0] CMD_OFS  = 8'h08;

    // command word bit positions (software visible)
    localparam int CMD_GO_BIT  = 31;
    localparam int CMD_WR_BIT  = 30;
    // control word bit positions
    localparam int CTL_IDLE_BIT = 31;
    localparam int CTL_EN_BIT   = 30;
    localparam int CTL_NOPRE_BIT = 20;

    localparam int PREAMBLE_BITS = 32;
    localparam int BODY_BITS     = 32;
    localparam int RX_FIELD_BITS = 18; // turnaround + data, released on reads
    localparam int DATA_BITS     = 16;

    typedef struct packed {
        logic        wr;
        logic [4:0]  regad;
        logic [4:0]  phy;
        logic [15:0] data;
    } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (st_q.cnt == div) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
            rise_stb = !st_q.mdc;
            fall_stb = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.cnt != div) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr,
    input  logic        nopre,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_i,
    input  logic        fall_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        cap_stb
);
    localparam int CNT_W = $clog2(PREAMBLE_BITS + BODY_BITS);

    typedef struct packed {
        logic                busy;
        logic                rd;
        logic [CNT_W-1:0]    cnt;
        logic [BODY_BITS-1:0] body;
    } fr_st_t;

    fr_st_t st_d, st_q;
    logic   in_pre;
    logic   in_rx_field;

    assign in_pre      = st_q.cnt[CNT_W-1];
    assign in_rx_field = !in_pre && (st_q.cnt[CNT_W-2:0] < (CNT_W-1)'(RX_FIELD_BITS));

    always_comb begin
        st_d = st_q;
        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.rd   = !wr;
            st_d.cnt  = nopre ? CNT_W'(BODY_BITS - 1) : CNT_W'(PREAMBLE_BITS + BODY_BITS - 1);
            st_d.body = {2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                         (wr ? 2'b10 : 2'b00), (wr ? wdata : 16'h0000)};
        end else if (st_q.busy && fall_i) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!st_q.busy || in_pre) mdio_o = 1'b1;
        else                      mdio_o = st_q.body[st_q.cnt[CNT_W-2:0]];
    end

    assign busy    = st_q.busy;
    assign mdio_oe = st_q.busy && !(st_q.rd && in_rx_field);
    assign cap_stb = st_q.busy && st_q.rd && rise_i && !in_pre &&
                     (st_q.cnt[CNT_W-2:0] < (CNT_W-1)'(DATA_BITS));

    p_out_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fall_i) |=> $stable(mdio_o));
    p_release_on_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic             en;
        logic             nopre;
        logic [DIV_W-1:0] div;
        cmd_t             cmd;
    } reg_st_t;

    reg_st_t rg_d, rg_q;
    logic    busy, rise_stb, fall_stb, cap_stb;
    logic    ctrl_hit, cmd_hit, start;
    logic    unused_wbits;

    assign ctrl_hit = host_wr && (host_addr == ADDR_W'(CTRL_OFS));
    assign cmd_hit  = host_wr && (host_addr == ADDR_W'(CMD_OFS));
    assign start    = cmd_hit && host_wdata[CMD_GO_BIT] && rg_q.en && !busy;
    assign unused_wbits = ^{host_wdata[29:26], host_wdata[19:DIV_W], host_wdata[31]};

    always_comb begin
        rg_d = rg_q;
        if (ctrl_hit) begin
            rg_d.en    = host_wdata[CTL_EN_BIT];
            rg_d.nopre = host_wdata[CTL_NOPRE_BIT];
            rg_d.div   = host_wdata[DIV_W-1:0];
        end
        if (cmd_hit && !busy) begin
            rg_d.cmd.wr    = host_wdata[CMD_WR_BIT];
            rg_d.cmd.regad = host_wdata[25:21];
            rg_d.cmd.phy   = host_wdata[20:16];
            rg_d.cmd.data  = host_wdata[15:0];
        end
        if (cap_stb) rg_d.cmd.data = {rg_q.cmd.data[14:0], mdio_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(CTRL_OFS)) begin
            host_rdata[CTL_IDLE_BIT]  = !busy;
            host_rdata[CTL_EN_BIT]    = rg_q.en;
            host_rdata[CTL_NOPRE_BIT] = rg_q.nopre;
            host_rdata[DIV_W-1:0]     = rg_q.div;
        end else if (host_addr == ADDR_W'(CMD_OFS)) begin
            host_rdata[CMD_GO_BIT] = busy;
            host_rdata[CMD_WR_BIT] = rg_q.cmd.wr;
            host_rdata[25:21]      = rg_q.cmd.regad;
            host_rdata[20:16]      = rg_q.cmd.phy;
            host_rdata[15:0]       = rg_q.cmd.data;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (rg_q.div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr      (host_wdata[CMD_WR_BIT]),
        .nopre   (rg_q.nopre),
        .phy     (host_wdata[20:16]),
        .regad   (host_wdata[25:21]),
        .wdata   (host_wdata[15:0]),
        .rise_i  (rise_stb),
        .fall_i  (fall_stb),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .cap_stb (cap_stb)
    );

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> ($stable(rg_q.cmd.wr) && $stable(rg_q.cmd.phy) &&
                               $stable(rg_q.cmd.regad)));
    p_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rg_q.en && !busy) |=> !busy);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    // PHY model state
    int          rcount = 0;
    int          cur_b = 64;
    logic        cur_rd = 1'b0;
    logic [15:0] resp = 16'h0;
    logic        got_o  [0:63];
    logic        got_oe [0:63];

    always #10 clk = !clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        if (rcount < 64) begin
            got_o[rcount]  = mdio_o;
            got_oe[rcount] = mdio_oe;
        end
        rcount = rcount + 1;
    end

    always @(negedge mdc) begin
        if (cur_rd && rcount >= cur_b - 16 && rcount < cur_b) mdio_i = resp[cur_b - 1 - rcount];
        else mdio_i = 1'b1;
    end

    // {wr, nopre, div[7:0], phy[4:0], reg[4:0], data/resp[15:0]}
    localparam logic [35:0] VEC [0:4] = '{
        {1'b1, 1'b0, 8'd1, 5'h01, 5'h00, 16'hA5C3},
        {1'b0, 1'b0, 8'd2, 5'h1F, 5'h02, 16'h1234},
        {1'b1, 1'b1, 8'd0, 5'h10, 5'h1F, 16'h8001},
        {1'b0, 1'b1, 8'd3, 5'h00, 5'h11, 16'hBEEF},
        {1'b0, 1'b0, 8'd0, 5'h0A, 5'h15, 16'h8001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic go, input logic wr,
                                             input logic [4:0] phy, input logic [4:0] ra,
                                             input logic [15:0] dat);
        return {go, wr, 4'b0000, ra, phy, dat};
    endfunction

    // Runs one frame; returns the number of clocks until busy cleared.
    task automatic run_frame(input logic wr, input logic nopre, input logic [7:0] dv,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] dat, input logic mid_write,
                             output int clocks);
        logic [31:0] rd;
        host_write(8'h04, {1'b0, 1'b1, 9'b0, nopre, 12'b0, dv});
        cur_b = nopre ? 32 : 64;
        cur_rd = !wr;
        resp = dat;
        rcount = 0;
        host_write(8'h08, cmd_word(1'b1, wr, phy, ra, wr ? dat : 16'h0000));
        clocks = 0;
        host_read(8'h08, rd);
        check("R3 busy after start", {31'b0, rd[31]}, 32'd1);
        host_read(8'h04, rd);
        check("R11 idle flag during frame", {31'b0, rd[31]}, 32'd0);
        if (mid_write) begin
            host_write(8'h08, cmd_word(1'b1, !wr, 5'h15, 5'h0A, 16'h5A5A));
            clocks = clocks + 2;
        end
        host_read(8'h08, rd);
        while (rd[31] && clocks < 10000) begin
            @(negedge clk);
            clocks = clocks + 1;
            host_read(8'h08, rd);
        end
    endtask

    task automatic check_wire(input logic wr, input logic nopre, input logic [4:0] phy,
                              input logic [4:0] ra, input logic [15:0] dat);
        int b;
        int base;
        logic [31:0] body;
        int bad_o;
        int bad_oe;
        b = nopre ? 32 : 64;
        base = nopre ? 0 : 32;
        body = {2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, dat};
        check("R4 MDC rising edges per frame", rcount, b);
        bad_o = 0; bad_oe = 0;
        for (int i = 0; i < b; i++) begin
            if (i < base) begin
                if (got_o[i] !== 1'b1) bad_o++;
                if (got_oe[i] !== 1'b1) bad_oe++;
            end else if (!wr && (i - base) >= 14) begin
                if (got_oe[i] !== 1'b0) bad_oe++;
            end else begin
                if (got_o[i] !== body[31 - (i - base)]) bad_o++;
                if (got_oe[i] !== 1'b1) bad_oe++;
            end
        end
        if (wr) check("R5 R6 R8 write frame bit errors", bad_o, 0);
        else    check("R5 R8 read header bit errors", bad_o, 0);
        if (wr) check("R6 output enable during write frame", bad_oe, 0);
        else    check("R7 driver release during read turnaround and data", bad_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int clocks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        host_read(8'h04, rd);
        check("R2 control after reset", rd, 32'h8000_0000);
        host_read(8'h08, rd);
        check("R1 command word after reset", rd, 32'h0);
        check("R4 idle MDC and enable", {30'b0, mdc, mdio_oe}, 32'h0);

        // table walk
        for (int v = 0; v < 5; v++) begin
            logic        wr;
            logic        np;
            logic [7:0]  dv;
            logic [4:0]  ph;
            logic [4:0]  ra;
            logic [15:0] dt;
            {wr, np, dv, ph, ra, dt} = VEC[v];
            run_frame(wr, np, dv, ph, ra, dt, 1'b0, clocks);
            check("R4 frame length in clocks", clocks, 2 * (np ? 32 : 64) * (dv + 1));
            check_wire(wr, np, ph, ra, dt);
            host_read(8'h08, rd);
            check(wr ? "R1 command readback after write" : "R7 R1 read data in command word",
                  rd, cmd_word(1'b0, wr, ph, ra, dt));
            host_read(8'h04, rd);
            check("R11 R2 idle flag after frame", rd, {1'b1, 1'b1, 9'b0, np, 12'b0, dv});
        end

        // write while busy is ignored
        run_frame(1'b1, 1'b1, 8'd1, 5'h03, 5'h04, 16'hC0DE, 1'b1, clocks);
        check("R9 frame length unaffected", clocks, 2 * 32 * 2);
        check_wire(1'b1, 1'b1, 5'h03, 5'h04, 16'hC0DE);
        host_read(8'h08, rd);
        check("R9 command fields unchanged", rd, cmd_word(1'b0, 1'b1, 5'h03, 5'h04, 16'hC0DE));

        // disabled block does not start
        host_write(8'h04, 32'h0000_0002);
        rcount = 0;
        host_write(8'h08, cmd_word(1'b1, 1'b0, 5'h01, 5'h01, 16'h0));
        host_read(8'h08, rd);
        check("R10 busy stays clear when disabled", {31'b0, rd[31]}, 32'd0);
        repeat (40) @(negedge clk);
        check("R10 no MDC edges when disabled", rcount, 0);
        check("R10 MDC low when disabled", {31'b0, mdc}, 32'd0);
        host_read(8'h04, rd);
        check("R11 idle flag when disabled", rd, 32'h8000_0002);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule